// File: doc/BRIEF.md
# Instruction-List Launch Controller

This block decides when a coprocessor's instruction-list executor starts, stops and changes to another list. A host processor reaches it through a small register window: a control register, a 16-bit primary list pointer, and a primary launch strobe. The running list reaches it through a second write port that can set a 16-bit alternate pointer, fire the alternate launch strobe and fire the primary strobe. The executor receives a start address, a memory bank number, a one-cycle launch pulse and a run level. The executor reports the end of each list with a one-cycle end pulse.

The block powers up locked. Only a two-byte key written to the control register opens it. Once it is open, an enable bit arms a primary launch at every frame boundary, and clearing that bit halts the executor at once. The strobes launch a list on the next cycle. An alternate launch can also switch the bank. When an alternate list finishes, the executor goes back to the primary pointer in whatever bank is selected at that point.

Top module: `lc_launch_ctrl`

## Requirements
- R1: After reset the block is locked. While locked, no write on either port changes a register or launches a list, and exec_run stays 0. The block unlocks when two consecutive control writes (host address 0) carry 0x42 and then 0x52. Writes to other addresses between these two do not count and do not break the sequence. The key bytes are not stored, so control reads 0x00 after unlocking. The block stays unlocked until reset.
- R2: While locked, a control write that does not continue the key sequence returns the key tracker to its start. Both 0x42,0x10,0x52 and 0x42,0x42,0x52 leave the block locked.
- R3: Control bit 3 is the enable. Setting it does not launch anything by itself. While it is 1, each frame_start pulse launches the primary list: on the next cycle exec_start is 1 for one cycle, exec_run is 1 and exec_addr equals {primary high, primary low}. While it is 0, frame_start has no effect.
- R4: A control write with bit 3 equal to 0 drops exec_run to 0 on the next cycle. This halt overrides any strobe, frame_start or list_end in the same cycle.
- R5: The primary pointer low and high bytes sit at host addresses 1 and 2 and read back as written.
- R6: A write of any value to address 3, from either port, launches the primary list on the next cycle, whether or not the enable bit is set.
- R7: A list-port write to address 6 launches the alternate list at {address 5, address 4} on the next cycle. If bit 3 of the written value is 1, bits 2:0 become exec_bank; otherwise the bank is unchanged. The primary pointer is never changed.
- R8: A list_end pulse during an alternate-launched list launches the primary pointer on the next cycle and keeps the current bank. A list_end during a primary-launched list drops exec_run to 0.
- R9: Host reads are combinational. Address 0 returns control, addresses 1 and 2 return the pointer bytes, and address 3 returns the version parameter in bits 7:3 and vid_std in bits 2:0.
- R10: A strobe beats frame_start in the same cycle, and the alternate strobe beats the primary strobe.
- R11: The host port ignores writes to addresses 4 to 6. The list port ignores writes to addresses 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 3 | Host register address (read and write) |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational |
| lst_wr | input | 1 | List-side write strobe |
| lst_addr | input | 3 | List-side register address |
| lst_wdata | input | 8 | List-side write data |
| vid_std | input | 3 | Video-standard code returned on reads of address 3 |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| list_end | input | 1 | One-cycle pulse from the executor at the end of a list |
| exec_run | output | 1 | Executor running |
| exec_start | output | 1 | One-cycle launch pulse |
| exec_addr | output | 16 | Address of the list being launched |
| exec_bank | output | 3 | Executor memory bank |

## Verification
The key tracker is tried with a clean key, a key broken by a foreign byte, a repeated first byte, and a clean key with a non-control write in between. These cases separate a tracker that resets on any mismatch from one that only looks at the last byte or counts every write. Launches are driven from a frame boundary, from each strobe on each port, and from an alternate end that chains into the primary list. Pairing these sources in the same cycle shows which one wins, and distinct pointer values make the winner visible on exec_addr. Alternate strobes with and without the bank-select bit check the bank against the launch address.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int AW = 3;
    localparam int DW = 8;
    localparam int PW = 2 * DW;
    localparam int BW = 3;
    localparam int VW = DW - BW;

    localparam logic [AW-1:0] RG_CTRL = 3'd0;
    localparam logic [AW-1:0] RG_PLO  = 3'd1;
    localparam logic [AW-1:0] RG_PHI  = 3'd2;
    localparam logic [AW-1:0] RG_PGO  = 3'd3;
    localparam logic [AW-1:0] RG_ALO  = 3'd4;
    localparam logic [AW-1:0] RG_AHI  = 3'd5;
    localparam logic [AW-1:0] RG_AGO  = 3'd6;

    localparam logic [DW-1:0] KEY_FIRST  = 8'h42;
    localparam logic [DW-1:0] KEY_SECOND = 8'h52;
    localparam int EN_BIT      = 3;
    localparam int BANKSEL_BIT = 3;

    typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;
    typedef enum logic [1:0] {LS_IDLE, LS_PRI, LS_ALT} lstate_e;

    typedef struct packed {
        logic          halt;
        logic          pri_go;
        logic          alt_go;
        logic          bank_set;
        logic [BW-1:0] bank_val;
    } evt_t;

    function automatic unlock_e unlock_next(unlock_e cur, logic [DW-1:0] d);
        unlock_e n;
        case (cur)
            UL_IDLE: n = (d == KEY_FIRST)  ? UL_HALF : UL_IDLE;
            UL_HALF: n = (d == KEY_SECOND) ? UL_OPEN : UL_IDLE;
            default: n = UL_OPEN;
        endcase
        return n;
    endfunction

    function automatic logic host_writable(logic [AW-1:0] a);
        return a <= RG_PGO;
    endfunction

    function automatic logic list_writable(logic [AW-1:0] a);
        return (a >= RG_PGO) && (a <= RG_AGO);
    endfunction

endpackage

// File: rtl/lc_unlock.sv
module lc_unlock
    import lc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    output logic          open_o
);

    unlock_e state_q;
    unlock_e state_d;

    always_comb begin
        state_d = state_q;
        if (key_wr) state_d = unlock_next(state_q, key_data);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= UL_IDLE;
        else     state_q <= state_d;
    end

    assign open_o = (state_q == UL_OPEN);

    // R1: once open, the block remains open until reset
    p_stays_open_r1: assert property (@(posedge clk) disable iff (rst)
        open_o |=> open_o);

    // R2: a half-entered key followed by a wrong byte stays locked
    p_wrong_second_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == UL_HALF && key_wr && key_data != KEY_SECOND) |=> !open_o);

endmodule

// File: rtl/lc_regs.sv
module lc_regs
    import lc_pkg::*;
#(
    parameter logic [VW-1:0] VERSION = 5'd3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          unlocked,
    input  logic          hst_wr,
    input  logic [AW-1:0] hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    input  logic          lst_wr,
    input  logic [AW-1:0] lst_addr,
    input  logic [DW-1:0] lst_wdata,
    input  logic [BW-1:0] vid_std,
    output logic          en_o,
    output logic [PW-1:0] pri_ptr,
    output logic [PW-1:0] alt_ptr,
    output evt_t          evt
);

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] plo_q, phi_q, alo_q, ahi_q;
    logic          h_acc, l_acc;
    logic          ctrl_we;

    assign h_acc   = hst_wr && unlocked && host_writable(hst_addr);
    assign l_acc   = lst_wr && unlocked && list_writable(lst_addr);
    assign ctrl_we = h_acc && (hst_addr == RG_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            plo_q  <= '0;
            phi_q  <= '0;
            alo_q  <= '0;
            ahi_q  <= '0;
        end else begin
            if (ctrl_we)                          ctrl_q <= hst_wdata;
            if (h_acc && hst_addr == RG_PLO)      plo_q  <= hst_wdata;
            if (h_acc && hst_addr == RG_PHI)      phi_q  <= hst_wdata;
            if (l_acc && lst_addr == RG_ALO)      alo_q  <= lst_wdata;
            if (l_acc && lst_addr == RG_AHI)      ahi_q  <= lst_wdata;
        end
    end

    always_comb begin
        evt          = '0;
        evt.halt     = ctrl_we && !hst_wdata[EN_BIT];
        evt.pri_go   = (h_acc && hst_addr == RG_PGO) || (l_acc && lst_addr == RG_PGO);
        evt.alt_go   = l_acc && (lst_addr == RG_AGO);
        evt.bank_set = evt.alt_go && lst_wdata[BANKSEL_BIT];
        evt.bank_val = lst_wdata[BW-1:0];
    end

    always_comb begin
        case (hst_addr)
            RG_CTRL: hst_rdata = ctrl_q;
            RG_PLO:  hst_rdata = plo_q;
            RG_PHI:  hst_rdata = phi_q;
            RG_PGO:  hst_rdata = {VERSION, vid_std};
            default: hst_rdata = '0;
        endcase
    end

    assign en_o    = ctrl_q[EN_BIT];
    assign pri_ptr = {phi_q, plo_q};
    assign alt_ptr = {ahi_q, alo_q};

    // R1: while locked, no register takes a write
    p_locked_no_store_r1: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> ($stable(pri_ptr) && $stable(ctrl_q) && $stable(alt_ptr)));

    // R7: the alternate launch never alters the primary pointer
    p_alt_keeps_pri_r7: assert property (@(posedge clk) disable iff (rst)
        (lst_wr && lst_addr == RG_AGO && !(hst_wr && (hst_addr == RG_PLO || hst_addr == RG_PHI)))
        |=> $stable(pri_ptr));

endmodule

// File: rtl/lc_launch.sv
module lc_launch
    import lc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          unlocked,
    input  logic          en,
    input  evt_t          evt,
    input  logic          frame_start,
    input  logic          list_end,
    input  logic [PW-1:0] pri_ptr,
    input  logic [PW-1:0] alt_ptr,
    output logic          run_o,
    output logic          start_o,
    output logic [PW-1:0] addr_o,
    output logic [BW-1:0] bank_o
);

    lstate_e       state_q, state_d;
    logic          start_d;
    logic [PW-1:0] addr_d;
    logic [BW-1:0] bank_d;
    logic          frame_go;

    assign frame_go = frame_start && en && unlocked;

    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        addr_d  = addr_o;
        bank_d  = bank_o;
        if (evt.bank_set) bank_d = evt.bank_val;
        if (evt.halt) begin
            state_d = LS_IDLE;
        end else if (evt.alt_go) begin
            state_d = LS_ALT;
            start_d = 1'b1;
            addr_d  = alt_ptr;
        end else if (evt.pri_go || frame_go) begin
            state_d = LS_PRI;
            start_d = 1'b1;
            addr_d  = pri_ptr;
        end else if (list_end) begin
            case (state_q)
                LS_ALT: begin
                    state_d = LS_PRI;
                    start_d = 1'b1;
                    addr_d  = pri_ptr;
                end
                LS_PRI:  state_d = LS_IDLE;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_IDLE;
            start_o <= 1'b0;
            addr_o  <= '0;
            bank_o  <= '0;
        end else begin
            state_q <= state_d;
            start_o <= start_d;
            addr_o  <= addr_d;
            bank_o  <= bank_d;
        end
    end

    assign run_o = (state_q != LS_IDLE);

    // R1: a locked block never runs the executor
    p_locked_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !run_o);

    // R4: a halt write stops the executor on the next cycle
    p_halt_stops_r4: assert property (@(posedge clk) disable iff (rst)
        evt.halt |=> !run_o);

    // R3: every launch pulse comes with the run level
    p_start_runs_r3: assert property (@(posedge clk) disable iff (rst)
        start_o |-> run_o);

    // R10: the alternate strobe outranks every other launch source
    p_alt_first_r10: assert property (@(posedge clk) disable iff (rst)
        (evt.alt_go && !evt.halt) |=> (start_o && addr_o == $past(alt_ptr)));

    // R8: the end of an alternate list chains into the primary list
    p_alt_end_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_ALT && list_end && !evt.halt && !evt.alt_go && !evt.pri_go && !frame_go)
        |=> (start_o && addr_o == $past(pri_ptr) && $stable(bank_o)));

endmodule

// File: rtl/lc_launch_ctrl.sv
module lc_launch_ctrl
    import lc_pkg::*;
#(
    parameter logic [VW-1:0] VERSION = 5'd3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hst_wr,
    input  logic [AW-1:0] hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    input  logic          lst_wr,
    input  logic [AW-1:0] lst_addr,
    input  logic [DW-1:0] lst_wdata,
    input  logic [BW-1:0] vid_std,
    input  logic          frame_start,
    input  logic          list_end,
    output logic          exec_run,
    output logic          exec_start,
    output logic [PW-1:0] exec_addr,
    output logic [BW-1:0] exec_bank
);

    logic          unlocked;
    logic          key_wr;
    logic          en;
    logic [PW-1:0] pri_ptr, alt_ptr;
    evt_t          evt;

    assign key_wr = hst_wr && (hst_addr == RG_CTRL) && !unlocked;

    lc_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_data (hst_wdata),
        .open_o   (unlocked)
    );

    lc_regs #(.VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .unlocked  (unlocked),
        .hst_wr    (hst_wr),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .hst_rdata (hst_rdata),
        .lst_wr    (lst_wr),
        .lst_addr  (lst_addr),
        .lst_wdata (lst_wdata),
        .vid_std   (vid_std),
        .en_o      (en),
        .pri_ptr   (pri_ptr),
        .alt_ptr   (alt_ptr),
        .evt       (evt)
    );

    lc_launch u_launch (
        .clk         (clk),
        .rst         (rst),
        .unlocked    (unlocked),
        .en          (en),
        .evt         (evt),
        .frame_start (frame_start),
        .list_end    (list_end),
        .pri_ptr     (pri_ptr),
        .alt_ptr     (alt_ptr),
        .run_o       (exec_run),
        .start_o     (exec_start),
        .addr_o      (exec_addr),
        .bank_o      (exec_bank)
    );

endmodule

// File: tb/lc_launch_ctrl_tb.sv
module lc_launch_ctrl_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_wr = 1'b0;
    logic [2:0]  hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        lst_wr = 1'b0;
    logic [2:0]  lst_addr = '0;
    logic [7:0]  lst_wdata = '0;
    logic [2:0]  vid_std = 3'b110;
    logic        frame_start = 1'b0;
    logic        list_end = 1'b0;
    logic        exec_run, exec_start;
    logic [15:0] exec_addr;
    logic [2:0]  exec_bank;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lc_launch_ctrl #(.VERSION(5'd3)) u_dut (
        .clk(clk), .rst(rst),
        .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .lst_wr(lst_wr), .lst_addr(lst_addr), .lst_wdata(lst_wdata),
        .vid_std(vid_std), .frame_start(frame_start), .list_end(list_end),
        .exec_run(exec_run), .exec_start(exec_start), .exec_addr(exec_addr), .exec_bank(exec_bank)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic hw, input logic [2:0] ha, input logic [7:0] hd,
                       input logic lw, input logic [2:0] la, input logic [7:0] ld,
                       input logic fs, input logic le);
        hst_wr = hw; hst_addr = ha; hst_wdata = hd;
        lst_wr = lw; lst_addr = la; lst_wdata = ld;
        frame_start = fs; list_end = le;
        @(posedge clk); #1;
        hst_wr = 1'b0; lst_wr = 1'b0; frame_start = 1'b0; list_end = 1'b0;
    endtask

    task automatic hw(input logic [2:0] a, input logic [7:0] d); cyc(1, a, d, 0, 0, 0, 0, 0); endtask
    task automatic lw(input logic [2:0] a, input logic [7:0] d); cyc(0, 0, 0, 1, a, d, 0, 0); endtask
    task automatic frame(); cyc(0, 0, 0, 0, 0, 0, 1, 0); endtask
    task automatic lend();  cyc(0, 0, 0, 0, 0, 0, 0, 1); endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        hst_addr = a; #1;
        chk(hst_rdata, exp, tag);
    endtask

    task automatic t_reset();
        chk(exec_run, 0, "R1 run low after reset");
        chk(exec_start, 0, "R1 start low after reset");
        chk(exec_bank, 0, "R7 bank zero after reset");
        rd(3'd3, 8'h1E, "R9 version and video code");
        rd(3'd0, 8'h00, "R9 control after reset");
    endtask

    task automatic t_lock();
        hw(3'd1, 8'h34);
        rd(3'd1, 8'h00, "R1 pointer write ignored while locked");
        hw(3'd3, 8'h00);
        chk(exec_start, 0, "R1 strobe ignored while locked");
        frame();
        chk(exec_run, 0, "R1 no run while locked");
        hw(3'd0, 8'h42); hw(3'd0, 8'h10); hw(3'd0, 8'h52);
        hw(3'd1, 8'h11);
        rd(3'd1, 8'h00, "R2 broken key keeps lock");
        hw(3'd0, 8'h42); hw(3'd0, 8'h42); hw(3'd0, 8'h52);
        hw(3'd1, 8'h11);
        rd(3'd1, 8'h00, "R2 repeated first byte keeps lock");
        hw(3'd0, 8'h42); hw(3'd1, 8'h55); hw(3'd0, 8'h52);
        hw(3'd1, 8'h34);
        rd(3'd1, 8'h34, "R1 unlocked after key with foreign write between");
        rd(3'd0, 8'h00, "R1 key bytes not stored");
    endtask

    task automatic t_pointers();
        hw(3'd2, 8'h12);
        rd(3'd2, 8'h12, "R5 high byte readback");
        rd(3'd1, 8'h34, "R5 low byte readback");
    endtask

    task automatic t_frame();
        hw(3'd0, 8'h08);
        chk(exec_run, 0, "R3 arming alone does not launch");
        rd(3'd0, 8'h08, "R9 control readback");
        frame();
        chk({exec_start, exec_run, exec_addr}, {2'b11, 16'h1234}, "R3 frame launches primary");
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        chk({exec_start, exec_run}, 2'b01, "R3 launch pulse lasts one cycle");
        lend();
        chk(exec_run, 0, "R8 primary end stops");
    endtask

    task automatic t_halt();
        frame();
        chk(exec_run, 1, "R3 relaunch on next frame");
        hw(3'd0, 8'h00);
        chk(exec_run, 0, "R4 clearing enable halts");
        frame();
        chk({exec_start, exec_run}, 2'b00, "R3 disabled frame ignored");
    endtask

    task automatic t_pstrobe();
        hw(3'd3, 8'hFF);
        chk({exec_start, exec_run, exec_addr}, {2'b11, 16'h1234}, "R6 host strobe launches");
        lend();
        lw(3'd3, 8'h00);
        chk({exec_start, exec_run}, 2'b11, "R6 list strobe launches");
        lend();
        chk(exec_run, 0, "R8 stop after primary end");
    endtask

    task automatic t_alt();
        lw(3'd4, 8'hCD); lw(3'd5, 8'hAB);
        lw(3'd6, 8'h00);
        chk({exec_start, exec_addr, exec_bank}, {1'b1, 16'hABCD, 3'd0}, "R7 alternate launch no bank");
        rd(3'd1, 8'h34, "R7 primary low unchanged");
        rd(3'd2, 8'h12, "R7 primary high unchanged");
        lend();
        chk({exec_start, exec_run, exec_addr}, {2'b11, 16'h1234}, "R8 alternate end chains to primary");
        lend();
        chk(exec_run, 0, "R8 chained primary end stops");
        lw(3'd6, 8'h0D);
        chk({exec_addr, exec_bank}, {16'hABCD, 3'd5}, "R7 alternate with bank select");
        lend();
        chk({exec_start, exec_addr, exec_bank}, {1'b1, 16'h1234, 3'd5}, "R8 chain keeps current bank");
        lend();
        lw(3'd6, 8'h02);
        chk({exec_addr, exec_bank}, {16'hABCD, 3'd5}, "R7 bank kept when select bit clear");
        lend(); lend();
    endtask

    task automatic t_prio();
        hw(3'd0, 8'h08);
        cyc(0, 0, 0, 1, 3'd6, 8'h00, 1, 0);
        chk({exec_start, exec_addr}, {1'b1, 16'hABCD}, "R10 strobe beats frame");
        lend(); lend();
        cyc(1, 3'd3, 8'h00, 1, 3'd6, 8'h00, 0, 0);
        chk({exec_start, exec_addr}, {1'b1, 16'hABCD}, "R10 alternate beats primary strobe");
        cyc(1, 3'd0, 8'h00, 1, 3'd6, 8'h00, 0, 0);
        chk({exec_start, exec_run}, 2'b00, "R4 halt beats alternate strobe");
    endtask

    task automatic t_ports();
        hw(3'd4, 8'h99);
        lw(3'd6, 8'h00);
        chk(exec_addr, 16'hABCD, "R11 host write to alternate pointer ignored");
        lend(); lend();
        lw(3'd1, 8'h77);
        rd(3'd1, 8'h34, "R11 list write to primary pointer ignored");
        lw(3'd0, 8'h08);
        rd(3'd0, 8'h00, "R11 list write to control ignored");
        frame();
        chk(exec_run, 0, "R11 list cannot arm frame launch");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_lock();
        t_pointers();
        t_frame();
        t_halt();
        t_pstrobe();
        t_alt();
        t_prio();
        t_ports();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule